// File: doc/BRIEF.md
# Physical Register Rename Stage

This block renames registers for an out-of-order core whose results live in an enlarged physical register file, not in a result-holding reorder buffer. Each issuing instruction presents two architectural source names and, optionally, one architectural destination name. The stage looks up the sources in a speculative map and returns their physical numbers. For a destination it takes a fresh physical register from a free pool and reports the mapping it replaces, so that the commit logic can hand that register back later.

Two maps are held. The speculative map is written at issue. The committed map is written only when an instruction retires. A destination therefore becomes architectural state only at commit. A flush discards all speculative work. The controller moves from state RUN to state RECOVER (transition FLUSH_TAKEN) and spends one cycle there. In that cycle the committed map is copied over the speculative map and the free pool is rebuilt from the committed map. The controller then returns to RUN (transition RECOVER_DONE). A flush that arrives while in RECOVER keeps it in RECOVER (transition RECOVER_AGAIN), and RUN without a flush stays in RUN (transition RUN_HOLD).

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i in both maps, physical registers 16 to 47 are free, the first destination allocated is physical 16, and `stall` is low.
- R2: `iss_phys_a` and `iss_phys_b` give the speculative mapping of `iss_src_a` and `iss_src_b`, including mappings written by instructions issued in earlier cycles.
- R3: An issued instruction with a destination receives the lowest-numbered free physical register on `iss_new_phys`. `iss_old_phys` gives the destination's prior speculative mapping. The speculative map takes the new mapping at the clock edge.
- R4: A source that names the same register as the destination of the same instruction reads the prior mapping, not the newly allocated one.
- R5: An instruction with `iss_has_dst` low allocates nothing, is not stalled by an empty pool, and leaves the map and the pool unchanged.
- R6: When the pool is empty and a valid instruction has a destination, `stall` is high, and neither the map nor the pool changes for that instruction.
- R7: A commit writes `cmt_new_phys` into the committed map for `cmt_arch` and returns `cmt_old_phys` to the pool, where it becomes allocatable from the next cycle.
- R8: In the cycle `flush` is high and in the following RECOVER cycle, `stall` is high and issue has no effect. From the cycle after RECOVER, every source lookup returns the committed mapping.
- R9: After recovery, the free pool holds exactly the physical registers not referenced by the committed map.
- R10: A commit presented in the same cycle as `flush` is kept in the committed map, and it is therefore visible in the restored speculative map.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | An instruction is presented for renaming |
| iss_src_a | input | 4 | First architectural source |
| iss_src_b | input | 4 | Second architectural source |
| iss_has_dst | input | 1 | Instruction writes a register |
| iss_dst | input | 4 | Architectural destination |
| iss_phys_a | output | 6 | Physical register for source A |
| iss_phys_b | output | 6 | Physical register for source B |
| iss_new_phys | output | 6 | Physical register allocated to the destination |
| iss_old_phys | output | 6 | Prior physical register of the destination |
| stall | output | 1 | Issue is refused this cycle |
| cmt_valid | input | 1 | A register-writing instruction retires |
| cmt_arch | input | 4 | Architectural destination of the retiring instruction |
| cmt_new_phys | input | 6 | Physical register it was given at issue |
| cmt_old_phys | input | 6 | Mapping it displaced at issue |
| flush | input | 1 | Discard all speculative mappings |

## Verification
The assertions assume that commits retire earlier renamings in program order and carry the exact triple reported at issue. They also assume that no renaming is committed twice, and that no commit arrives during RECOVER, since every in-flight instruction has then been discarded. The bench keeps a queue of issued renamings and commits only from its head. It empties the queue when it raises `flush`, and it issues flushes only from RUN, so the random traffic remains within these assumptions.

// File: rtl/rename_pkg.sv
package rename_pkg;
    localparam int ARCH_REGS = 16;
    localparam int PHYS_REGS = 48;

    typedef enum logic [0:0] {
        ST_RUN     = 1'b0,
        ST_RECOVER = 1'b1
    } rn_state_e;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table #(
    parameter int ENTRIES = 16,
    parameter int VAL_W   = 6,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [VAL_W-1:0]                wr_val,
    input  logic                            load_en,
    input  logic [ENTRIES-1:0][VAL_W-1:0]   load_val,
    output logic [ENTRIES-1:0][VAL_W-1:0]   map_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) begin
                map_q[i] <= VAL_W'(i);
            end
        end else if (load_en) begin
            map_q <= load_val;
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_val;
        end
    end
endmodule

// File: rtl/rn_free_pool.sv
module rn_free_pool #(
    parameter int NPHYS  = 48,
    parameter int NARCH  = 16,
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_en,
    input  logic                         rel_en,
    input  logic [PW-1:0]                rel_idx,
    input  logic                         rebuild_en,
    input  logic [NARCH-1:0][PW-1:0]     ref_map,
    output logic [NPHYS-1:0]             free_q,
    output logic [PW-1:0]                alloc_idx,
    output logic                         empty
);
    logic [NPHYS-1:0] free_d;

    // lowest-numbered free register wins
    always_comb begin
        alloc_idx = '0;
        for (int p = NPHYS - 1; p >= 0; p--) begin
            if (free_q[p]) alloc_idx = PW'(p);
        end
    end

    assign empty = ~|free_q;

    always_comb begin
        free_d = free_q;
        if (rebuild_en) begin
            free_d = '1;
            for (int a = 0; a < NARCH; a++) begin
                free_d[ref_map[a]] = 1'b0;
            end
        end else begin
            if (alloc_en) free_d[alloc_idx] = 1'b0;
            if (rel_en)   free_d[rel_idx]   = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPHYS; p++) begin
                free_q[p] <= (p >= NARCH);
            end
        end else begin
            free_q <= free_d;
        end
    end
endmodule

// File: rtl/rn_ctrl.sv
module rn_ctrl
    import rename_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic iss_valid,
    input  logic iss_has_dst,
    input  logic pool_empty,
    output logic in_recover,
    output logic stall,
    output logic fire
);
    rn_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:     state_d = flush ? ST_RECOVER : ST_RUN;
            ST_RECOVER: state_d = flush ? ST_RECOVER : ST_RUN;
            default:    state_d = ST_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    always_comb begin
        in_recover = 1'b0;
        stall      = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                stall = flush || (iss_valid && iss_has_dst && pool_empty);
            end
            ST_RECOVER: begin
                in_recover = 1'b1;
                stall      = 1'b1;
            end
            default: stall = 1'b1;
        endcase
        fire = iss_valid && !stall;
    end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
    import rename_pkg::*;
#(
    parameter int NARCH  = ARCH_REGS,
    parameter int NPHYS  = PHYS_REGS,
    localparam int AW    = $clog2(NARCH),
    localparam int PW    = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          iss_valid,
    input  logic [AW-1:0] iss_src_a,
    input  logic [AW-1:0] iss_src_b,
    input  logic          iss_has_dst,
    input  logic [AW-1:0] iss_dst,
    output logic [PW-1:0] iss_phys_a,
    output logic [PW-1:0] iss_phys_b,
    output logic [PW-1:0] iss_new_phys,
    output logic [PW-1:0] iss_old_phys,
    output logic          stall,
    input  logic          cmt_valid,
    input  logic [AW-1:0] cmt_arch,
    input  logic [PW-1:0] cmt_new_phys,
    input  logic [PW-1:0] cmt_old_phys,
    input  logic          flush
);
    logic [NARCH-1:0][PW-1:0] spec_q;
    logic [NARCH-1:0][PW-1:0] comm_q;
    logic [NARCH-1:0][PW-1:0] comm_next;
    logic [NPHYS-1:0]         free_q;
    logic                     pool_empty;
    logic                     in_recover;
    logic                     fire;
    logic                     alloc_en;

    rn_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush      (flush),
        .iss_valid  (iss_valid),
        .iss_has_dst(iss_has_dst),
        .pool_empty (pool_empty),
        .in_recover (in_recover),
        .stall      (stall),
        .fire       (fire)
    );

    assign alloc_en = fire && iss_has_dst;

    // committed state as it stands after this cycle's retirement
    always_comb begin
        comm_next = comm_q;
        if (cmt_valid) comm_next[cmt_arch] = cmt_new_phys;
    end

    rn_map_table #(.ENTRIES(NARCH), .VAL_W(PW)) u_spec_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (alloc_en),
        .wr_idx  (iss_dst),
        .wr_val  (iss_new_phys),
        .load_en (in_recover),
        .load_val(comm_next),
        .map_q   (spec_q)
    );

    rn_map_table #(.ENTRIES(NARCH), .VAL_W(PW)) u_comm_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmt_valid),
        .wr_idx  (cmt_arch),
        .wr_val  (cmt_new_phys),
        .load_en (1'b0),
        .load_val(comm_q),
        .map_q   (comm_q)
    );

    rn_free_pool #(.NPHYS(NPHYS), .NARCH(NARCH)) u_pool (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_en  (alloc_en),
        .rel_en    (cmt_valid),
        .rel_idx   (cmt_old_phys),
        .rebuild_en(in_recover),
        .ref_map   (comm_next),
        .free_q    (free_q),
        .alloc_idx (iss_new_phys),
        .empty     (pool_empty)
    );

    assign iss_phys_a   = spec_q[iss_src_a];
    assign iss_phys_b   = spec_q[iss_src_b];
    assign iss_old_phys = spec_q[iss_dst];
endmodule

// File: rtl/rename_checker.sv
module rename_checker #(
    parameter int NARCH = 16,
    parameter int NPHYS = 48,
    localparam int PW   = $clog2(NPHYS)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush,
    input logic                     stall,
    input logic                     iss_valid,
    input logic                     iss_has_dst,
    input logic [PW-1:0]            iss_new_phys,
    input logic                     cmt_valid,
    input logic [PW-1:0]            cmt_old_phys,
    input logic                     in_recover,
    input logic [NPHYS-1:0]         free_q,
    input logic [NARCH-1:0][PW-1:0] spec_q,
    input logic [NARCH-1:0][PW-1:0] comm_q
);
    assert_alloc_from_pool_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !stall && iss_has_dst) |-> free_q[iss_new_phys]);

    assert_stall_holds_pool_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !flush && !in_recover && !cmt_valid) |=> $stable(free_q));

    assert_release_returns_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |=> free_q[$past(cmt_old_phys)]);

    assert_flush_stalls_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (stall && in_recover));

    assert_restore_map_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recover && !flush) |=> (spec_q == comm_q));

    assert_pool_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_recover && !flush) |=> ($countones(free_q) >= NPHYS - NARCH));
endmodule

bind rename_unit rename_checker #(.NARCH(NARCH), .NPHYS(NPHYS)) u_rename_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (flush),
    .stall       (stall),
    .iss_valid   (iss_valid),
    .iss_has_dst (iss_has_dst),
    .iss_new_phys(iss_new_phys),
    .cmt_valid   (cmt_valid),
    .cmt_old_phys(cmt_old_phys),
    .in_recover  (in_recover),
    .free_q      (free_q),
    .spec_q      (spec_q),
    .comm_q      (comm_q)
);

// File: tb/tb_rename_unit.sv
module tb_rename_unit;
    localparam int CLK_PERIOD = 10;
    localparam int NA = 16;
    localparam int NP = 48;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       iss_valid, iss_has_dst, cmt_valid, flush;
    logic [3:0] iss_src_a, iss_src_b, iss_dst, cmt_arch;
    logic [5:0] iss_phys_a, iss_phys_b, iss_new_phys, iss_old_phys;
    logic [5:0] cmt_new_phys, cmt_old_phys;
    logic       stall;

    always #(CLK_PERIOD/2) clk = ~clk;

    rename_unit dut (
        .clk(clk), .rst_n(rst_n),
        .iss_valid(iss_valid), .iss_src_a(iss_src_a), .iss_src_b(iss_src_b),
        .iss_has_dst(iss_has_dst), .iss_dst(iss_dst),
        .iss_phys_a(iss_phys_a), .iss_phys_b(iss_phys_b),
        .iss_new_phys(iss_new_phys), .iss_old_phys(iss_old_phys),
        .stall(stall),
        .cmt_valid(cmt_valid), .cmt_arch(cmt_arch),
        .cmt_new_phys(cmt_new_phys), .cmt_old_phys(cmt_old_phys),
        .flush(flush)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int m_spec[NA];
    int m_comm[NA];
    bit m_free[NP];
    bit m_rec;
    int q_arch[64], q_new[64], q_old[64];
    int q_head, q_tail, q_cnt;

    task automatic chk(input int act, input int exp, input string tag);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int lowest_free();
        for (int p = 0; p < NP; p++) if (m_free[p]) return p;
        return -1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NA; i++) begin m_spec[i] = i; m_comm[i] = i; end
        for (int p = 0; p < NP; p++) m_free[p] = (p >= NA);
        m_rec = 0; q_head = 0; q_tail = 0; q_cnt = 0;
    endtask

    // one issue cycle: drive after negedge, check, then advance the model
    task automatic step(input bit v, input int a, input int b, input bit hd,
                        input int d, input bit want_cmt, input bit fl);
        bit exp_stall, do_cmt, fired;
        int lf, ca, cn, co;
        @(negedge clk);
        iss_valid = v; iss_src_a = 4'(a); iss_src_b = 4'(b);
        iss_has_dst = hd; iss_dst = 4'(d); flush = fl;
        do_cmt = want_cmt && (q_cnt > 0);
        ca = 0; cn = 0; co = 0;
        if (do_cmt) begin
            ca = q_arch[q_head]; cn = q_new[q_head]; co = q_old[q_head];
            q_head = (q_head + 1) % 64; q_cnt--;
        end
        cmt_valid = do_cmt; cmt_arch = 4'(ca); cmt_new_phys = 6'(cn); cmt_old_phys = 6'(co);
        #1;
        lf = lowest_free();
        exp_stall = fl || m_rec || (v && hd && lf < 0);
        chk(int'(stall), int'(exp_stall), (fl || m_rec) ? "R8 stall" : (hd ? "R6 stall" : "R5 stall"));
        fired = v && !exp_stall;
        if (fired) begin
            chk(int'(iss_phys_a), m_spec[a], "R2 src_a");
            chk(int'(iss_phys_b), m_spec[b], (b == d) ? "R4 src_b" : "R2 src_b");
            if (hd) begin
                chk(int'(iss_new_phys), lf, "R3 new_phys");
                chk(int'(iss_old_phys), m_spec[d], "R3 old_phys");
            end
        end
        if (m_rec) begin
            if (do_cmt) m_comm[ca] = cn;
            for (int p = 0; p < NP; p++) m_free[p] = 1;
            for (int i = 0; i < NA; i++) begin m_spec[i] = m_comm[i]; m_free[m_comm[i]] = 0; end
        end else begin
            if (do_cmt) begin m_comm[ca] = cn; m_free[co] = 1; end
            if (fired && hd) begin
                q_arch[q_tail] = d; q_new[q_tail] = lf; q_old[q_tail] = m_spec[d];
                q_tail = (q_tail + 1) % 64; q_cnt++;
                m_free[lf] = 0; m_spec[d] = lf;
            end
        end
        m_rec = fl;
        if (fl) begin q_head = 0; q_tail = 0; q_cnt = 0; end
    endtask

    // read every speculative mapping through source A with no issue
    task automatic probe_map(input string tag);
        for (int i = 0; i < NA; i++) begin
            @(negedge clk);
            iss_valid = 0; iss_has_dst = 0; cmt_valid = 0; flush = 0;
            iss_src_a = 4'(i);
            #1;
            chk(int'(iss_phys_a), m_spec[i], tag);
        end
        chk(int'(iss_new_phys), lowest_free(), "R9 lowest free");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        rst_n = 0; iss_valid = 0; iss_has_dst = 0; cmt_valid = 0; flush = 0;
        iss_src_a = 0; iss_src_b = 0; iss_dst = 0; cmt_arch = 0;
        cmt_new_phys = 0; cmt_old_phys = 0;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1 reset state
        probe_map("R1 reset map");
        chk(int'(iss_new_phys), 16, "R1 first free");
        chk(int'(stall), 0, "R1 stall low");

        // R4 source equal to destination, then R2 sees the new mapping
        step(1, 3, 3, 1, 3, 0, 0);
        step(1, 3, 5, 1, 7, 0, 0);

        // R6 exhaust the pool without commits
        for (int k = 0; k < 36; k++) step(1, k % NA, (k + 5) % NA, 1, k % NA, 0, 0);
        // R5 no-destination instruction passes an empty pool
        step(1, 2, 9, 0, 4, 0, 0);
        step(1, 1, 2, 1, 6, 0, 0);
        // R7 one commit frees a register that the next issue receives
        step(0, 0, 0, 0, 0, 1, 0);
        step(1, 8, 3, 1, 11, 0, 0);

        // R10 commit in the flush cycle, then R8/R9 recovery
        step(0, 0, 0, 0, 0, 1, 1);
        step(1, 4, 4, 1, 4, 0, 0);
        probe_map("R8 restored map");

        // R5 after recovery: no-dst then dst
        step(1, 5, 6, 0, 5, 0, 0);
        step(1, 5, 6, 1, 5, 0, 0);

        for (int n = 0; n < 4000; n++) begin
            bit v, hd, cm, fl;
            v  = ($urandom % 8) != 0;
            hd = ($urandom % 4) != 0;
            cm = ($urandom % 5) < 2;
            fl = !m_rec && (($urandom % 40) == 0);
            step(v, $urandom % NA, $urandom % NA, hd, $urandom % NA, cm, fl);
            if (fl) begin
                step(0, 0, 0, 0, 0, 0, 0);
                probe_map("R8 random restore");
            end
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule